// File: doc/BRIEF.md
# Two-channel prescaled interval timer

A timer peripheral with two independent 16-bit up-counting channels, programmed over a plain register bus with a write strobe and 16-bit data. Each channel has four registers: control, event status, load (terminal value) and count. A channel counts up from zero at the input clock divided by a power of two. When the count reaches the load value, the channel raises a latched event. In one-shot mode it then stops. In auto-reload mode it returns to zero on the next prescaled tick and keeps going.

Software can read the running count at any time. A load of 0xFFFF in auto-reload mode turns a channel into a free-running 16-bit time base. Each channel drives its own interrupt line: the latched event gated by the channel's interrupt-enable bit. Reads are combinational from the address; writes take effect on the rising clock edge where the strobe is high.

Top module: `ivtimer`

## Requirements
- R1: Channel n (n = 0, 1) decodes at base 0x80 + n*0x80: control at base+0x0, status at base+0x4, load at base+0x8, count at base+0xC. Reads of any other offset return 0. Writes to other offsets, and writes to the count register, change nothing.
- R2: Control fields: bit 8 is interrupt enable, bit 5 is run enable, bit 4 selects one-shot (1) or auto-reload (0), and bits 3:0 hold the prescaler code k. A control read returns these fields with all other bits 0.
- R3: While running, the count advances once every 2^k input clocks. Codes 9 to 15 behave as k = 8 (divide by 256).
- R4: A control write that sets run enable while the channel is stopped zeroes the count and the prescaler. The first increment lands 2^k clock edges after the write edge.
- R5: In one-shot mode, on the edge where the count reaches the load value, status bit 0 sets, run enable clears, and the count then holds.
- R6: In auto-reload mode, status bit 0 sets on each edge where the count reaches the load value, and the next tick returns the count to 0. With load 0xFFFF the count runs through every value and wraps.
- R7: The interrupt line of a channel is high exactly when its status bit 0 and its interrupt enable are both 1.
- R8: Writing status with bit 0 = 1 clears the status; writing 0 leaves it. A match in the same cycle as the clear wins.
- R9: Clearing run enable freezes the count. A load value written while stopped governs the run after the next enable.
- R10: A control write that keeps run enable at 1 updates mode, prescaler and interrupt enable without zeroing the count.
- R11: After reset, all registers read 0 and both interrupt lines are low.
- R12: The two channels are independent; activity on one never alters the other's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 9 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
A write that starts a channel at edge E0 gives count c at edge E0 + c*2^k. The status bit and the one-shot stop land on the same edge where the count reaches the load value. The interrupt line and read data follow in that same cycle, because both are combinational from the registers. The bench changes inputs 2 ns after a rising edge and compares every output against a behavioural model at the falling edge, so each result is checked in the cycle in which it is due. The directed checks wait an exact number of edges computed from the load and prescaler before they read.

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int NCH    = 2,
  parameter int AW     = 9,
  parameter int DW     = 16,
  parameter int PMAX   = 8,
  parameter int BASE   = 'h80,
  parameter int STRIDE = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NCH-1:0]     irq
);
  localparam int PW = PMAX;

  logic [NCH-1:0]          en_q, os_q, ie_q, st_q;
  logic [NCH-1:0][3:0]     psc_q;
  logic [NCH-1:0][DW-1:0]  cnt_q, ld_q, rd_v;
  logic [NCH-1:0][PW-1:0]  pcnt_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int B = BASE + i * STRIDE;
    logic wr_ctl, wr_st, wr_ld, tick, hit;
    logic [3:0]    kk;
    logic [PW:0]   one_sh;
    logic [PW-1:0] lim;
    logic [DW-1:0] nxt;

    assign wr_ctl = bus_wr && bus_addr == AW'(B);
    assign wr_st  = bus_wr && bus_addr == AW'(B + 4);
    assign wr_ld  = bus_wr && bus_addr == AW'(B + 8);
    assign kk     = (psc_q[i] > 4'(PMAX)) ? 4'(PMAX) : psc_q[i];
    assign one_sh = (PW+1)'(1) << kk;
    assign lim    = PW'(one_sh - 1'b1);
    assign tick   = en_q[i] && pcnt_q[i] >= lim;
    assign nxt    = (!os_q[i] && cnt_q[i] == ld_q[i]) ? '0 : cnt_q[i] + 1'b1;
    assign hit    = tick && nxt == ld_q[i];
    assign irq[i] = st_q[i] & ie_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i] <= 1'b0; os_q[i] <= 1'b0; ie_q[i] <= 1'b0; st_q[i] <= 1'b0;
        psc_q[i] <= '0; cnt_q[i] <= '0; ld_q[i] <= '0; pcnt_q[i] <= '0;
      end else begin
        if (tick) begin
          cnt_q[i]  <= nxt;
          pcnt_q[i] <= '0;
          if (hit && os_q[i]) en_q[i] <= 1'b0;
        end else if (en_q[i]) begin
          pcnt_q[i] <= pcnt_q[i] + 1'b1;
        end
        if (wr_ctl) begin
          ie_q[i]  <= bus_wdata[8];
          en_q[i]  <= bus_wdata[5];
          os_q[i]  <= bus_wdata[4];
          psc_q[i] <= bus_wdata[3:0];
          if (bus_wdata[5] && !en_q[i]) begin
            cnt_q[i]  <= '0;
            pcnt_q[i] <= '0;
          end
        end
        if (wr_ld) ld_q[i] <= bus_wdata;
        if (hit) st_q[i] <= 1'b1;
        else if (wr_st && bus_wdata[0]) st_q[i] <= 1'b0;
      end
    end

    always_comb begin
      rd_v[i] = '0;
      if (bus_addr == AW'(B))          rd_v[i] = DW'({ie_q[i], 2'b00, en_q[i], os_q[i], psc_q[i]});
      else if (bus_addr == AW'(B + 4)) rd_v[i] = DW'(st_q[i]);
      else if (bus_addr == AW'(B + 8)) rd_v[i] = ld_q[i];
      else if (bus_addr == AW'(B + 12)) rd_v[i] = cnt_q[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | rd_v[i];
  end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
  parameter int NCH    = 2,
  parameter int AW     = 9,
  parameter int DW     = 16,
  parameter int BASE   = 'h80,
  parameter int STRIDE = 'h80
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [NCH-1:0]          en,
  input logic [NCH-1:0]          st,
  input logic [NCH-1:0]          ie,
  input logic [NCH-1:0]          irq,
  input logic [NCH-1:0][DW-1:0]  cnt
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    logic ctl_wr;
    assign ctl_wr = bus_wr && bus_addr == AW'(BASE + i * STRIDE);

    a_r11_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (cnt[i] == '0 && !st[i] && !en[i] && !irq[i]));

    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !ctl_wr) |=> $stable(cnt[i]));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && $past(en[i])) |-> (cnt[i] == $past(cnt[i]) ||
        cnt[i] == DW'($past(cnt[i]) + 1'b1) || cnt[i] == '0));

    a_r5_status_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[i]) |-> $past(en[i]));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> (ie[i] && st[i]));
  end
endmodule

bind ivtimer ivtimer_chk #(.NCH(NCH), .AW(AW), .DW(DW), .BASE(BASE), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .en(en_q), .st(st_q), .ie(ie_q), .irq(irq), .cnt(cnt_q));

// File: tb/sim_ivtimer.sv
`timescale 1ns/1ps
module sim_ivtimer;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;
  int checks = 0, errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  ivtimer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
              .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference
  int m_cnt[2], m_pc[2], m_ld[2], m_psc[2];
  bit m_en[2], m_os[2], m_ie[2], m_st[2];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      int b, div, nx;
      bit tk, hit, oe;
      if (!rst_n) begin
        m_cnt[c] = 0; m_pc[c] = 0; m_ld[c] = 0; m_psc[c] = 0;
        m_en[c] = 0; m_os[c] = 0; m_ie[c] = 0; m_st[c] = 0;
      end else begin
        b = 128 + 128 * c;
        div = 1 << ((m_psc[c] > 8) ? 8 : m_psc[c]);
        oe = m_en[c];
        tk = m_en[c] && (m_pc[c] >= div - 1);
        hit = 0;
        if (tk) begin
          nx = (!m_os[c] && m_cnt[c] == m_ld[c]) ? 0 : (m_cnt[c] + 1) % 65536;
          hit = (nx == m_ld[c]);
          m_cnt[c] = nx; m_pc[c] = 0;
          if (hit && m_os[c]) m_en[c] = 0;
        end else if (m_en[c]) m_pc[c]++;
        if (bus_wr && bus_addr == b) begin
          m_ie[c] = bus_wdata[8]; m_en[c] = bus_wdata[5];
          m_os[c] = bus_wdata[4]; m_psc[c] = bus_wdata[3:0];
          if (bus_wdata[5] && !oe) begin m_cnt[c] = 0; m_pc[c] = 0; end
        end
        if (bus_wr && bus_addr == b + 8) m_ld[c] = bus_wdata;
        if (hit) m_st[c] = 1;
        else if (bus_wr && bus_addr == b + 4 && bus_wdata[0]) m_st[c] = 0;
      end
    end
  end

  function automatic int m_read(int a);
    for (int c = 0; c < 2; c++) begin
      int b = 128 + 128 * c;
      if (a == b) return (int'(m_ie[c]) << 8) | (int'(m_en[c]) << 5) | (int'(m_os[c]) << 4) | m_psc[c];
      if (a == b + 4) return int'(m_st[c]);
      if (a == b + 8) return m_ld[c];
      if (a == b + 12) return m_cnt[c];
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R1 reads, R7 interrupts)
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(bus_rdata) == m_read(bus_addr), "R1 read vs model", bus_rdata, m_read(bus_addr));
    chk(irq[0] == (m_st[0] && m_ie[0]), "R7 irq0 vs model", irq[0], m_st[0] && m_ie[0]);
    chk(irq[1] == (m_st[1] && m_ie[1]), "R7 irq1 vs model", irq[1], m_st[1] && m_ie[1]);
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    bus_wr = 1; bus_addr = 9'(a); bus_wdata = 16'(d);
    @(posedge clk); #2;
    bus_wr = 0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = 9'(a); #1; v = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_rd(int a, int exp, string tag);
    int v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    edges(3);
    #1 rst_n = 1;
    // R11 reset state
    expect_rd('h080, 0, "R11 ctrl0"); expect_rd('h08C, 0, "R11 count0");
    expect_rd('h104, 0, "R11 status1"); expect_rd('h108, 0, "R11 load1");
    chk(irq == 2'b00, "R11 irq", irq, 0);

    // R2 field readback, stray bits dropped, no run
    wr('h080, 'hFFDF);
    expect_rd('h080, 'h011F, "R2 ctrl readback");
    edges(5);
    expect_rd('h08C, 0, "R2 no run without enable");
    wr('h080, 0);

    // R1 unmapped and count writes ignored
    wr('h004, 'hFFFF); wr('h08C, 'h1234); wr('h110, 'h55);
    expect_rd('h004, 0, "R1 unmapped read");
    expect_rd('h090, 0, "R1 unmapped read in gap");
    expect_rd('h08C, 0, "R1 count write ignored");

    // R4 R5 one-shot, load 5, k=1: count 5 at edge 10
    wr('h088, 5);
    wr('h080, 'h0131);
    edges(9);
    expect_rd('h08C, 4, "R3 R4 count after 9 edges");
    expect_rd('h084, 0, "R5 no event yet");
    edges(1);
    expect_rd('h08C, 5, "R5 count at load");
    expect_rd('h084, 1, "R5 status set");
    expect_rd('h080, 'h0111, "R5 enable self-cleared");
    chk(irq[0] == 1, "R7 irq0 raised", irq[0], 1);
    edges(6);
    expect_rd('h08C, 5, "R5 count holds after stop");

    // R8 write 0 keeps, write 1 clears
    wr('h084, 0);
    expect_rd('h084, 1, "R8 write 0 no effect");
    wr('h084, 1);
    expect_rd('h084, 0, "R8 write 1 clears");
    chk(irq[0] == 0, "R8 irq0 dropped", irq[0], 0);

    // R6 auto-reload ch1 load 3, k=0
    wr('h108, 3);
    wr('h100, 'h0120);
    edges(3);
    expect_rd('h10C, 3, "R6 reaches load");
    expect_rd('h104, 1, "R6 status set");
    edges(1);
    expect_rd('h10C, 0, "R6 returns to zero");
    expect_rd('h08C, 5, "R12 channel 0 untouched");
    expect_rd('h084, 0, "R12 channel 0 status untouched");

    // R10 control write while enabled keeps count
    edges(1);
    wr('h100, 'h0122);
    rd('h10C, v);
    chk(v != 0 && v == m_cnt[1], "R10 count kept on ctrl write", v, m_cnt[1]);
    edges(9);

    // R9 stop freezes, new load used on next enable
    wr('h100, 'h0100);
    rd('h10C, v);
    edges(20);
    expect_rd('h10C, v, "R9 count frozen");
    wr('h108, 7);
    wr('h104, 1);
    wr('h100, 'h0120);
    edges(6);
    expect_rd('h104, 0, "R9 no event before new load");
    edges(1);
    expect_rd('h10C, 7, "R9 new load reached");
    expect_rd('h104, 1, "R9 event at new load");
    wr('h100, 0);

    // R3 prescaler code 12 clamps to 256
    wr('h088, 'h10);
    wr('h080, 'h002C);
    edges(255);
    expect_rd('h08C, 0, "R3 no step before 256");
    edges(1);
    expect_rd('h08C, 1, "R3 step at 256");
    edges(512);
    expect_rd('h08C, 3, "R3 steady divide 256");
    wr('h080, 0);

    // R6 free-running wrap with load 0xFFFF
    wr('h084, 1);
    wr('h088, 'hFFFF);
    wr('h080, 'h0020);
    edges(65535);
    expect_rd('h08C, 'hFFFF, "R6 reaches 0xFFFF");
    expect_rd('h084, 1, "R6 status at 0xFFFF");
    edges(1);
    expect_rd('h08C, 0, "R6 wraps to zero");
    edges(10);
    expect_rd('h08C, 10, "R6 keeps running");
    chk(irq[0] == 0, "R7 irq gated by disable", irq[0], 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule